// File: doc/BRIEF.md
# Platform Reset Pulse Generator

This block produces timed reset pulses for a host processor complex without touching any power rail. A one-cycle request strobe, qualified by a kind select, starts one of two pulses. A cold request pulls the active-low platform reset line low for a long interval. That interval is always longer than the debounce filter of the receiving reset input. A warm request pulls the active-low processor init line low for a short interval. The processor is re-initialised, while the platform reset and all supplies stay untouched.

Both pulse lengths are derived at elaboration from the clock frequency in kHz and from time parameters. One shared down-counter times whichever pulse is active. A busy flag covers the whole pulse, and requests that arrive while it is high are dropped. The block senses the actual level of the platform reset wire. It refuses a cold request if some other agent is already holding that wire low.

Top module: `reset_pulser`

## Requirements
- R1: While `rst` is high and after it, until a request is accepted, `sys_rst_n_o` and `cpu_init_n_o` are 1 and `busy_o` is 0.
- R2: When idle, a request (`start_i`=1 with `cold_sel_i`=1) sampled at a rising edge while `sys_rst_sense_n_i`=1 drives `sys_rst_n_o` to 0 from the next cycle for exactly COLD_CYC cycles, then back to 1.
- R3: COLD_CYC = max(ceil(COLD_US·CLK_KHZ/1000), floor(DEBOUNCE_US·CLK_KHZ/1000)+1). The cold pulse therefore spans strictly more cycles than the debounce interval, even when COLD_US is set shorter than DEBOUNCE_US.
- R4: A cold request sampled while `sys_rst_sense_n_i`=0 has no effect: `busy_o` stays 0 and both lines stay 1.
- R5: When idle, a request with `cold_sel_i`=0 drives `cpu_init_n_o` to 0 from the next cycle for exactly WARM_CYC = max(ceil(WARM_NS·CLK_KHZ/10^6), ceil(MIN_WARM_NS·CLK_KHZ/10^6)) cycles, then back to 1.
- R6: A warm pulse leaves `sys_rst_n_o` at 1 and a cold pulse leaves `cpu_init_n_o` at 1; the two lines are never low together.
- R7: `busy_o` is 1 in exactly the cycles in which one of the two lines is low.
- R8: A request sampled while `busy_o`=1 is ignored, including on the final cycle of a pulse. A request sampled on the first cycle after a pulse ends is accepted.
- R9: A warm request is accepted whatever the level of `sys_rst_sense_n_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock of frequency CLK_KHZ kHz |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request strobe |
| cold_sel_i | input | 1 | 1 selects the cold pulse, 0 selects the warm pulse |
| sys_rst_sense_n_i | input | 1 | Observed level of the platform reset wire |
| sys_rst_n_o | output | 1 | Active-low platform reset drive |
| cpu_init_n_o | output | 1 | Active-low processor init drive |
| busy_o | output | 1 | High for the whole duration of a pulse |

## Verification
The hardest situations to reach from the ports are the edges of the busy window. One is a request that lands on the very last low cycle of a pulse, which must still be dropped. The other is a request on the first idle cycle after it, which must start a new pulse. The stimulus follows each pulse cycle by cycle and fires an opposite-kind request at a chosen offset. The offsets include zero, the final low cycle and random points in between. The next request is then issued immediately on the first high cycle. Random sense levels cover both the refused cold case and the warm case that ignores the sense level.

// File: rtl/reset_pulser_pkg.sv
package reset_pulser_pkg;

    typedef enum logic [1:0] {
        PS_IDLE = 2'd0,
        PS_COLD = 2'd1,
        PS_WARM = 2'd2
    } pulse_state_e;

    typedef struct packed {
        logic valid;
        logic cold;
    } pulse_req_t;

    function automatic longint max2(input longint a, input longint b);
        return (a > b) ? a : b;
    endfunction

    function automatic longint ceil_cycles(input longint khz, input longint ns);
        return (khz * ns + 64'd999_999) / 64'd1_000_000;
    endfunction

    function automatic longint floor_cycles(input longint khz, input longint ns);
        return (khz * ns) / 64'd1_000_000;
    endfunction

    // Long pulse: requested length, but always beyond the debounce window.
    function automatic longint cold_cycles(input longint khz, input longint len_us,
                                           input longint deb_us);
        return max2(max2(ceil_cycles(khz, len_us * 1000),
                         floor_cycles(khz, deb_us * 1000) + 1), 1);
    endfunction

    // Short pulse: requested length, never below the minimum width.
    function automatic longint warm_cycles(input longint khz, input longint len_ns,
                                           input longint min_ns);
        return max2(max2(ceil_cycles(khz, len_ns), ceil_cycles(khz, min_ns)), 1);
    endfunction

endpackage

// File: rtl/reset_pulser_cnt.sv
module reset_pulser_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic [W-1:0] value_i,
    output logic         done_o
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= value_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done_o = (cnt_q == '0);
endmodule

// File: rtl/reset_pulser_fsm.sv
module reset_pulser_fsm
    import reset_pulser_pkg::*;
#(
    parameter int           W       = 8,
    parameter logic [W-1:0] COLD_LD = '1,
    parameter logic [W-1:0] WARM_LD = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start_i,
    input  logic         cold_sel_i,
    input  logic         sense_n_i,
    input  logic         done_i,
    output logic         load_o,
    output logic [W-1:0] load_val_o,
    output pulse_state_e state_o
);
    pulse_state_e state_q, state_d;
    pulse_req_t   req;

    always_comb begin
        req.cold  = cold_sel_i;
        req.valid = start_i && (state_q == PS_IDLE) && (!cold_sel_i || sense_n_i);
    end

    always_comb begin
        state_d    = state_q;
        load_o     = 1'b0;
        load_val_o = req.cold ? COLD_LD : WARM_LD;
        unique case (state_q)
            PS_IDLE: begin
                if (req.valid) begin
                    load_o  = 1'b1;
                    state_d = req.cold ? PS_COLD : PS_WARM;
                end
            end
            PS_COLD, PS_WARM: begin
                if (done_i) state_d = PS_IDLE;
            end
            default: state_d = PS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= PS_IDLE;
        else     state_q <= state_d;
    end

    assign state_o = state_q;
endmodule

// File: rtl/reset_pulser.sv
module reset_pulser
    import reset_pulser_pkg::*;
#(
    parameter int CLK_KHZ     = 100_000,
    parameter int COLD_US     = 20_000,
    parameter int DEBOUNCE_US = 16_000,
    parameter int WARM_NS     = 10_000,
    parameter int MIN_WARM_NS = 500
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic cold_sel_i,
    input  logic sys_rst_sense_n_i,
    output logic sys_rst_n_o,
    output logic cpu_init_n_o,
    output logic busy_o
);
    localparam int COLD_CYC = int'(cold_cycles(CLK_KHZ, COLD_US, DEBOUNCE_US));
    localparam int WARM_CYC = int'(warm_cycles(CLK_KHZ, WARM_NS, MIN_WARM_NS));
    localparam int MAX_CYC  = (COLD_CYC > WARM_CYC) ? COLD_CYC : WARM_CYC;
    localparam int CNT_W    = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] COLD_LD = CNT_W'(COLD_CYC - 1);
    localparam logic [CNT_W-1:0] WARM_LD = CNT_W'(WARM_CYC - 1);

    logic             load;
    logic [CNT_W-1:0] load_val;
    logic             done;
    pulse_state_e     state;

    reset_pulser_fsm #(
        .W       (CNT_W),
        .COLD_LD (COLD_LD),
        .WARM_LD (WARM_LD)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .cold_sel_i (cold_sel_i),
        .sense_n_i  (sys_rst_sense_n_i),
        .done_i     (done),
        .load_o     (load),
        .load_val_o (load_val),
        .state_o    (state)
    );

    reset_pulser_cnt #(
        .W (CNT_W)
    ) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .load_i  (load),
        .value_i (load_val),
        .done_o  (done)
    );

    assign sys_rst_n_o  = (state != PS_COLD);
    assign cpu_init_n_o = (state != PS_WARM);
    assign busy_o       = (state != PS_IDLE);
endmodule

// File: rtl/reset_pulser_chk.sv
module reset_pulser_chk #(
    parameter int COLD_CYC = 2,
    parameter int WARM_CYC = 2
) (
    input logic clk,
    input logic rst,
    input logic start_i,
    input logic cold_sel_i,
    input logic sys_rst_sense_n_i,
    input logic sys_rst_n_o,
    input logic cpu_init_n_o,
    input logic busy_o
);
    int sys_run, cpu_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            sys_run <= 0;
            cpu_run <= 0;
        end else begin
            sys_run <= sys_rst_n_o  ? 0 : sys_run + 1;
            cpu_run <= cpu_init_n_o ? 0 : cpu_run + 1;
        end
    end

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (sys_rst_n_o && cpu_init_n_o && !busy_o));

    assert_cold_start_R2: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o && cold_sel_i && sys_rst_sense_n_i) |=> !sys_rst_n_o);

    assert_cold_width_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(sys_rst_n_o) |-> (sys_run == COLD_CYC));

    assert_cold_refused_R4: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o && cold_sel_i && !sys_rst_sense_n_i) |=> !busy_o);

    assert_warm_width_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(cpu_init_n_o) |-> (cpu_run == WARM_CYC));

    assert_lines_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
        (sys_rst_n_o || cpu_init_n_o));

    assert_busy_match_R7: assert property (@(posedge clk) disable iff (rst)
        busy_o == (!sys_rst_n_o || !cpu_init_n_o));

    assert_sys_fall_cause_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(sys_rst_n_o) |-> $past(start_i && !busy_o && cold_sel_i && sys_rst_sense_n_i));

    assert_cpu_fall_cause_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(cpu_init_n_o) |-> $past(start_i && !busy_o && !cold_sel_i));
endmodule

bind reset_pulser reset_pulser_chk #(
    .COLD_CYC (COLD_CYC),
    .WARM_CYC (WARM_CYC)
) u_chk (
    .clk               (clk),
    .rst               (rst),
    .start_i           (start_i),
    .cold_sel_i        (cold_sel_i),
    .sys_rst_sense_n_i (sys_rst_sense_n_i),
    .sys_rst_n_o       (sys_rst_n_o),
    .cpu_init_n_o      (cpu_init_n_o),
    .busy_o            (busy_o)
);

// File: tb/test_reset_pulser.sv
`timescale 1ns/1ps
module test_reset_pulser;
    localparam int CLK_KHZ     = 250_000;
    localparam int COLD_US     = 12;
    localparam int DEBOUNCE_US = 16;
    localparam int WARM_NS     = 1000;
    localparam int MIN_WARM_NS = 500;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_i = 1'b0;
    logic cold_sel_i = 1'b0;
    logic sys_rst_sense_n_i = 1'b1;
    logic sys_rst_n_o, cpu_init_n_o, busy_o;

    int compared = 0;
    int mismatched = 0;

    always #2 clk = ~clk;

    reset_pulser #(
        .CLK_KHZ     (CLK_KHZ),
        .COLD_US     (COLD_US),
        .DEBOUNCE_US (DEBOUNCE_US),
        .WARM_NS     (WARM_NS),
        .MIN_WARM_NS (MIN_WARM_NS)
    ) i_reset_pulser (
        .clk               (clk),
        .rst               (rst),
        .start_i           (start_i),
        .cold_sel_i        (cold_sel_i),
        .sys_rst_sense_n_i (sys_rst_sense_n_i),
        .sys_rst_n_o       (sys_rst_n_o),
        .cpu_init_n_o      (cpu_init_n_o),
        .busy_o            (busy_o)
    );

    // Expected widths from R3 and R5.
    function automatic int exp_cold();
        longint want = (longint'(CLK_KHZ) * COLD_US + 999) / 1000;
        longint deb  = (longint'(CLK_KHZ) * DEBOUNCE_US) / 1000 + 1;
        return int'((want > deb) ? want : deb);
    endfunction

    function automatic int exp_warm();
        longint want = (longint'(CLK_KHZ) * WARM_NS + 999_999) / 1_000_000;
        longint lo   = (longint'(CLK_KHZ) * MIN_WARM_NS + 999_999) / 1_000_000;
        return int'((want > lo) ? want : lo);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_idle(input int cycles, input string req);
        bit ok = 1'b1;
        for (int i = 0; i < cycles; i++) begin
            if (busy_o || !sys_rst_n_o || !cpu_init_n_o) ok = 1'b0;
            @(negedge clk);
        end
        check(ok, req, {29'd0, busy_o, sys_rst_n_o, cpu_init_n_o}, 3);
    endtask

    // Issue one request; intrude = low-cycle index at which an opposite
    // request is fired (beyond the pulse means none).
    task automatic fire(input bit cold, input bit sense, input int intrude);
        bit accept = !cold || sense;
        int exp_w  = cold ? exp_cold() : exp_warm();
        int w = 0;
        bit other_ok = 1'b1;
        bit busy_ok  = 1'b1;
        start_i = 1'b1; cold_sel_i = cold; sys_rst_sense_n_i = sense;
        @(negedge clk);
        start_i = 1'b0;
        if (!accept) begin
            check_idle(4, "R4 cold refused while sense low");
            return;
        end
        while ((cold ? !sys_rst_n_o : !cpu_init_n_o) && w < 20000) begin
            if (cold ? !cpu_init_n_o : !sys_rst_n_o) other_ok = 1'b0;
            if (!busy_o) busy_ok = 1'b0;
            if (w == intrude) begin
                start_i = 1'b1; cold_sel_i = ~cold; sys_rst_sense_n_i = 1'b1;
            end else begin
                start_i = 1'b0;
            end
            w++;
            @(negedge clk);
        end
        start_i = 1'b0;
        if (cold) check(w == exp_w, "R2/R3 cold width", w, exp_w);
        else      check(w == exp_w, sense ? "R5 warm width" : "R9 warm width with sense low", w, exp_w);
        check(other_ok, "R6 other line untouched", int'(other_ok), 1);
        check(busy_ok && !busy_o, "R7 busy tracks pulse", int'(busy_o), 0);
        if (intrude < w) check_idle(3, "R8 request during busy ignored");
    endtask

    initial begin
        repeat (190_000) @(posedge clk);
        compared++;
        mismatched++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check(sys_rst_n_o && cpu_init_n_o && !busy_o, "R1 outputs during reset",
              {29'd0, busy_o, sys_rst_n_o, cpu_init_n_o}, 3);
        rst = 1'b0;
        check_idle(3, "R1 idle after reset");

        // Directed corners
        fire(1'b0, 1'b1, 1_000_000);            // plain warm
        fire(1'b1, 1'b1, 1_000_000);            // plain cold, clamped by debounce
        fire(1'b1, 1'b0, 0);                    // cold refused
        fire(1'b0, 1'b0, 1_000_000);            // warm with sense low
        fire(1'b0, 1'b1, 0);                    // intrusion on first low cycle
        fire(1'b0, 1'b1, exp_warm() - 1);       // intrusion on last low cycle
        fire(1'b1, 1'b1, exp_cold() - 1);       // same for cold
        fire(1'b1, 1'b1, 1_000_000);            // back-to-back accept
        fire(1'b0, 1'b1, 1_000_000);            // back-to-back accept of other kind
        check_idle(2, "R8 idle after back-to-back");

        // Random mix
        for (int n = 0; n < 24; n++) begin
            bit cold  = ($urandom % 3) == 0;
            bit sense = ($urandom % 4) != 0;
            int len   = cold ? exp_cold() : exp_warm();
            int intr  = ($urandom % 2) ? int'($urandom % len) : 1_000_000;
            int gap   = $urandom % 5;
            repeat (gap) @(negedge clk);
            fire(cold, sense, intr);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule